// File: doc/BRIEF.md
# ADC Pre-Trigger Sequencing Channel

This block sits beside a shared period counter and turns it into a short, ordered burst of conversion requests for one analog-to-digital converter. It owns a parameterized set of pre-trigger slots (2, 4 or 8). Each slot selects one conversion setup on the converter. A slot launches either when the counter reaches the slot's delay value, or, in chained mode, when the converter reports that the conversion of the slot just below it has finished. A channel-level trigger line frames the whole burst.

Each slot has three configuration bits: enable, output-select and chain. It also has a delay that is double-buffered: new values go into a shadow copy, and a load strobe moves them into the working copy. The block keeps a sticky match flag and a sticky error flag per slot. An error means that a slot launched while an earlier conversion of the channel had not yet completed. A maskable interrupt line reports any error. The counter and the converter are outside the block.

Top module: `adc_pretrig_seq`

## Requirements
- R1: While reset is held and in the cycle after it, pt_fire, trig_out, match_flags, err_flags and err_irq are all zero.
- R2: A slot i with enable and output-select set and not in chained mode produces a one-cycle pulse on pt_fire[i] in the cycle after cnt_val equals its working delay. It fires at most once until the next cnt_restart pulse, even if the counter holds that value.
- R3: A slot whose enable or output-select bit is zero never pulses pt_fire.
- R4: A slot i>0 in chained mode pulses pt_fire[i] in the cycle after a conv_done that completes the outstanding conversion of slot i-1. The chain bit of slot 0 is ignored, so slot 0 always uses its delay.
- R5: At most one bit of pt_fire is high in any cycle. When several slots request at once, the lowest index fires first and the rest fire one per cycle in ascending order.
- R6: match_flags[i] sets with each pulse of pt_fire[i] and stays set until a cycle with clr_match[i] high.
- R7: err_flags[i] sets when slot i fires while a conversion is outstanding and no conv_done arrives in that cycle. It stays set until a cycle with clr_err[i] high.
- R8: err_irq is high exactly when err_irq_en is high and at least one err_flags bit is set.
- R9: trig_out rises with the first pt_fire pulse of a burst and stays high. It falls in the cycle after a conv_done that completes the conversion of the highest-indexed slot with enable and output-select set.
- R10: A delay write goes to a shadow copy and does not change when any slot fires until ld_strobe is pulsed. After the load, the new value is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | DLY_W | Shared period counter value |
| cnt_restart | input | 1 | Pulse at the start of a counter period; re-arms delay slots |
| ld_strobe | input | 1 | Copies all shadow delays into the working delays |
| dly_wr_en | input | 1 | Shadow delay write enable |
| dly_wr_idx | input | IDX_W | Slot index for the shadow write |
| dly_wr_val | input | DLY_W | Shadow delay value |
| pt_enable | input | NUM_PT | Per-slot enable |
| pt_outsel | input | NUM_PT | Per-slot output select |
| pt_chain | input | NUM_PT | Per-slot chained (back-to-back) mode |
| conv_done | input | 1 | Converter completion pulse |
| clr_match | input | NUM_PT | Clear request for match flags |
| clr_err | input | NUM_PT | Clear request for error flags |
| err_irq_en | input | 1 | Error interrupt enable |
| pt_fire | output | NUM_PT | One-hot pre-trigger pulse selecting the conversion setup |
| trig_out | output | 1 | Channel trigger framing a burst |
| match_flags | output | NUM_PT | Sticky per-slot fire flags |
| err_flags | output | NUM_PT | Sticky per-slot overlap error flags |
| err_irq | output | 1 | Masked error interrupt |

## Verification
The embedded properties assume that conv_done is a single-cycle pulse and that configuration bits change only between bursts. They also assume that the converter's completion and the counter are driven by outside logic in any order. The properties do not depend on the counter counting monotonically, because every check compares flags and pulses against the previous cycle's grant or armed state. The stimulus changes enable, output-select and chain bits only when no conversion is outstanding, and it issues loads and shadow writes on cycles where the counter matches no slot. It also steps the counter through chosen values instead of free-running it, so every launch cycle is known in advance.

// File: rtl/ptseq_pkg.sv
package ptseq_pkg;

    localparam int MAX_PT    = 8;
    localparam int SLOT_IDXW = 3;

    // Outstanding conversion bookkeeping for the channel.
    typedef struct packed {
        logic                 busy;
        logic [SLOT_IDXW-1:0] idx;
    } conv_slot_t;

    // Index of the single set bit of a one-hot vector (0 when empty).
    function automatic logic [SLOT_IDXW-1:0] onehot_idx(input logic [MAX_PT-1:0] v);
        logic [SLOT_IDXW-1:0] r;
        r = '0;
        for (int k = 0; k < MAX_PT; k++) begin
            if (v[k]) r = r | SLOT_IDXW'(k);
        end
        return r;
    endfunction

    // Index of the highest set bit (0 when empty).
    function automatic logic [SLOT_IDXW-1:0] highest_idx(input logic [MAX_PT-1:0] v);
        logic [SLOT_IDXW-1:0] r;
        r = '0;
        for (int k = 0; k < MAX_PT; k++) begin
            if (v[k]) r = SLOT_IDXW'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/ptseq_dly_bank.sv
module ptseq_dly_bank #(
    parameter int NUM_PT = 4,
    parameter int DLY_W  = 16,
    localparam int IDX_W = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DLY_W-1:0]               wr_val,
    input  logic                           load,
    output logic [NUM_PT-1:0][DLY_W-1:0]   act_dly
);

    logic [NUM_PT-1:0][DLY_W-1:0] shadow_q;
    logic [NUM_PT-1:0][DLY_W-1:0] act_q;

    generate
        for (genvar i = 0; i < NUM_PT; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    shadow_q[i] <= '0;
                    act_q[i]    <= '0;
                end else begin
                    if (wr_en && (wr_idx == IDX_W'(i))) begin
                        shadow_q[i] <= wr_val;
                    end
                    if (load) begin
                        act_q[i] <= shadow_q[i];
                    end
                end
            end

            // R10
            act_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(load) && !$past(rst)) |-> $stable(act_q[i]));
        end
    endgenerate

    assign act_dly = act_q;

endmodule

// File: rtl/ptseq_arbiter.sv
module ptseq_arbiter #(
    parameter int NUM_PT = 4,
    parameter int DLY_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DLY_W-1:0]              cnt_val,
    input  logic                          cnt_restart,
    input  logic [NUM_PT-1:0][DLY_W-1:0]  act_dly,
    input  logic [NUM_PT-1:0]             armed,
    input  logic [NUM_PT-1:0]             chain_mode,
    input  logic [NUM_PT-1:0]             chain_evt,
    output logic [NUM_PT-1:0]             grant,
    output logic [NUM_PT-1:0]             fire_q
);

    logic [NUM_PT-1:0] fired_q;
    logic [NUM_PT-1:0] pend_q;
    logic [NUM_PT-1:0] delay_evt;
    logic [NUM_PT-1:0] link_evt;
    logic [NUM_PT-1:0] req;

    generate
        for (genvar i = 0; i < NUM_PT; i++) begin : g_match
            assign delay_evt[i] = armed[i] & ~chain_mode[i] & ~fired_q[i]
                                & (cnt_val == act_dly[i]);
        end
    endgenerate

    always_comb begin
        link_evt = armed & chain_mode & chain_evt;
        req      = (delay_evt | link_evt | pend_q) & armed;
        grant    = req & (~req + NUM_PT'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q <= '0;
            pend_q  <= '0;
            fire_q  <= '0;
        end else begin
            fired_q <= cnt_restart ? '0 : (fired_q | delay_evt);
            pend_q  <= req & ~grant;
            fire_q  <= grant;
        end
    end

    // R5
    fire_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire_q));

    // R3
    fire_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_q & ~$past(armed)) == '0);

endmodule

// File: rtl/ptseq_tracker.sv
module ptseq_tracker
    import ptseq_pkg::*;
#(
    parameter int NUM_PT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] grant,
    input  logic [NUM_PT-1:0] armed,
    input  logic              conv_done,
    input  logic [NUM_PT-1:0] clr_match,
    input  logic [NUM_PT-1:0] clr_err,
    output logic [NUM_PT-1:0] chain_evt,
    output logic [NUM_PT-1:0] match_q,
    output logic [NUM_PT-1:0] err_q,
    output logic              trig_q
);

    conv_slot_t           slot_q;
    conv_slot_t           slot_d;
    logic                 grant_any;
    logic                 done_eff;
    logic                 overlap;
    logic [SLOT_IDXW-1:0] gidx;
    logic [SLOT_IDXW-1:0] last_idx;

    always_comb begin
        grant_any = |grant;
        gidx      = onehot_idx(MAX_PT'(grant));
        last_idx  = highest_idx(MAX_PT'(armed));
        done_eff  = conv_done & slot_q.busy;
        overlap   = grant_any & slot_q.busy & ~conv_done;
        slot_d    = slot_q;
        if (grant_any) begin
            slot_d.busy = 1'b1;
            slot_d.idx  = gidx;
        end else if (done_eff) begin
            slot_d.busy = 1'b0;
        end
    end

    assign chain_evt[0] = 1'b0;
    generate
        for (genvar i = 1; i < NUM_PT; i++) begin : g_link
            assign chain_evt[i] = done_eff && (slot_q.idx == SLOT_IDXW'(i - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= '0;
            match_q <= '0;
            err_q   <= '0;
            trig_q  <= 1'b0;
        end else begin
            slot_q  <= slot_d;
            match_q <= (match_q & ~clr_match) | grant;
            err_q   <= (err_q & ~clr_err) | ({NUM_PT{overlap}} & grant);
            if (grant_any) begin
                trig_q <= 1'b1;
            end else if (done_eff && (slot_q.idx == last_idx)) begin
                trig_q <= 1'b0;
            end
        end
    end

    // R6
    match_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((match_q & ~$past(match_q)) & ~$past(grant)) == '0);

    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        ((err_q & ~$past(err_q)) & ~$past(grant)) == '0);

    // R9
    trig_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_q) |-> $past(|grant));

endmodule

// File: rtl/adc_pretrig_seq.sv
module adc_pretrig_seq #(
    parameter int NUM_PT = 4,
    parameter int DLY_W  = 16,
    localparam int IDX_W = (NUM_PT > 1) ? $clog2(NUM_PT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DLY_W-1:0]  cnt_val,
    input  logic              cnt_restart,
    input  logic              ld_strobe,
    input  logic              dly_wr_en,
    input  logic [IDX_W-1:0]  dly_wr_idx,
    input  logic [DLY_W-1:0]  dly_wr_val,
    input  logic [NUM_PT-1:0] pt_enable,
    input  logic [NUM_PT-1:0] pt_outsel,
    input  logic [NUM_PT-1:0] pt_chain,
    input  logic              conv_done,
    input  logic [NUM_PT-1:0] clr_match,
    input  logic [NUM_PT-1:0] clr_err,
    input  logic              err_irq_en,
    output logic [NUM_PT-1:0] pt_fire,
    output logic              trig_out,
    output logic [NUM_PT-1:0] match_flags,
    output logic [NUM_PT-1:0] err_flags,
    output logic              err_irq
);

    logic [NUM_PT-1:0][DLY_W-1:0] act_dly;
    logic [NUM_PT-1:0]            armed;
    logic [NUM_PT-1:0]            chain_mode;
    logic [NUM_PT-1:0]            chain_evt;
    logic [NUM_PT-1:0]            grant;

    assign armed      = pt_enable & pt_outsel;
    assign chain_mode = {pt_chain[NUM_PT-1:1], 1'b0};

    ptseq_dly_bank #(.NUM_PT(NUM_PT), .DLY_W(DLY_W)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dly_wr_en),
        .wr_idx  (dly_wr_idx),
        .wr_val  (dly_wr_val),
        .load    (ld_strobe),
        .act_dly (act_dly)
    );

    ptseq_arbiter #(.NUM_PT(NUM_PT), .DLY_W(DLY_W)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .cnt_val     (cnt_val),
        .cnt_restart (cnt_restart),
        .act_dly     (act_dly),
        .armed       (armed),
        .chain_mode  (chain_mode),
        .chain_evt   (chain_evt),
        .grant       (grant),
        .fire_q      (pt_fire)
    );

    ptseq_tracker #(.NUM_PT(NUM_PT)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .armed     (armed),
        .conv_done (conv_done),
        .clr_match (clr_match),
        .clr_err   (clr_err),
        .chain_evt (chain_evt),
        .match_q   (match_flags),
        .err_q     (err_flags),
        .trig_q    (trig_out)
    );

    assign err_irq = err_irq_en & (|err_flags);

endmodule

// File: tb/adc_pretrig_seq_bench.sv
module adc_pretrig_seq_bench;

    localparam int N  = 4;
    localparam int DW = 16;
    localparam int NV = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] cnt_val = 16'd100;
    logic          cnt_restart = 1'b0;
    logic          ld_strobe = 1'b0;
    logic          dly_wr_en = 1'b0;
    logic [1:0]    dly_wr_idx = '0;
    logic [DW-1:0] dly_wr_val = '0;
    logic [N-1:0]  pt_enable = '0;
    logic [N-1:0]  pt_outsel = '0;
    logic [N-1:0]  pt_chain = '0;
    logic          conv_done = 1'b0;
    logic [N-1:0]  clr_match = '0;
    logic [N-1:0]  clr_err = '0;
    logic          err_irq_en = 1'b0;
    logic [N-1:0]  pt_fire;
    logic          trig_out;
    logic [N-1:0]  match_flags;
    logic [N-1:0]  err_flags;
    logic          err_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_pretrig_seq #(.NUM_PT(N), .DLY_W(DW)) u_adc_pretrig_seq (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_restart(cnt_restart),
        .ld_strobe(ld_strobe), .dly_wr_en(dly_wr_en), .dly_wr_idx(dly_wr_idx),
        .dly_wr_val(dly_wr_val), .pt_enable(pt_enable), .pt_outsel(pt_outsel),
        .pt_chain(pt_chain), .conv_done(conv_done), .clr_match(clr_match),
        .clr_err(clr_err), .err_irq_en(err_irq_en), .pt_fire(pt_fire),
        .trig_out(trig_out), .match_flags(match_flags), .err_flags(err_flags),
        .err_irq(err_irq)
    );

    // Vector: {cnt[30:15], restart[14], done[13], fire[12:9], trig[8], match[7:4], err[3:0]}
    // Delays: slot0=5, slot1=10, slot2 chained from slot1, slot3=20; all armed.
    localparam logic [30:0] VEC [NV] = '{
        {16'd0,  1'b1, 1'b0, 4'b0000, 1'b0, 4'b0000, 4'b0000},
        {16'd4,  1'b0, 1'b0, 4'b0000, 1'b0, 4'b0000, 4'b0000},
        {16'd5,  1'b0, 1'b0, 4'b0001, 1'b1, 4'b0001, 4'b0000},
        {16'd5,  1'b0, 1'b0, 4'b0000, 1'b1, 4'b0001, 4'b0000},
        {16'd6,  1'b0, 1'b1, 4'b0000, 1'b1, 4'b0001, 4'b0000},
        {16'd10, 1'b0, 1'b0, 4'b0010, 1'b1, 4'b0011, 4'b0000},
        {16'd11, 1'b0, 1'b1, 4'b0100, 1'b1, 4'b0111, 4'b0000},
        {16'd12, 1'b0, 1'b0, 4'b0000, 1'b1, 4'b0111, 4'b0000},
        {16'd20, 1'b0, 1'b0, 4'b1000, 1'b1, 4'b1111, 4'b1000},
        {16'd21, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b1111, 4'b1000},
        {16'd22, 1'b0, 1'b0, 4'b0000, 1'b0, 4'b1111, 4'b1000},
        {16'd0,  1'b1, 1'b0, 4'b0000, 1'b0, 4'b1111, 4'b1000},
        {16'd5,  1'b0, 1'b0, 4'b0001, 1'b1, 4'b1111, 4'b1000},
        {16'd6,  1'b0, 1'b1, 4'b0000, 1'b1, 4'b1111, 4'b1000},
        {16'd10, 1'b0, 1'b0, 4'b0010, 1'b1, 4'b1111, 4'b1000},
        {16'd11, 1'b0, 1'b1, 4'b0100, 1'b1, 4'b1111, 4'b1000},
        {16'd12, 1'b0, 1'b1, 4'b0000, 1'b1, 4'b1111, 4'b1000},
        {16'd20, 1'b0, 1'b0, 4'b1000, 1'b1, 4'b1111, 4'b1000},
        {16'd21, 1'b0, 1'b1, 4'b0000, 1'b0, 4'b1111, 4'b1000}
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive at edge+2ns, advance one edge, return at edge+2ns.
    task automatic step(input logic [15:0] c, input logic rs, input logic dn);
        cnt_val     = c;
        cnt_restart = rs;
        conv_done   = dn;
        @(posedge clk);
        #2;
        cnt_restart = 1'b0;
        conv_done   = 1'b0;
    endtask

    task automatic wr_dly(input logic [1:0] idx, input logic [15:0] v);
        dly_wr_en  = 1'b1;
        dly_wr_idx = idx;
        dly_wr_val = v;
        step(16'd100, 1'b0, 1'b0);
        dly_wr_en  = 1'b0;
    endtask

    task automatic do_load();
        ld_strobe = 1'b1;
        step(16'd100, 1'b0, 1'b0);
        ld_strobe = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int w = 0; w < 5000; w++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state while held
        chk("R1", "fire", 16'(pt_fire), 16'h0);
        chk("R1", "trig", 16'(trig_out), 16'h0);
        rst = 1'b0;
        step(16'd100, 1'b0, 1'b0);
        // R1 cycle after reset
        chk("R1", "match", 16'(match_flags), 16'h0);
        chk("R1", "err", 16'(err_flags), 16'h0);
        chk("R1", "irq", 16'(err_irq), 16'h0);

        wr_dly(2'd0, 16'd5);
        wr_dly(2'd1, 16'd10);
        wr_dly(2'd2, 16'd0);
        wr_dly(2'd3, 16'd20);
        do_load();
        pt_enable = 4'b1111;
        pt_outsel = 4'b1111;
        pt_chain  = 4'b0100;

        // R2 R4 R6 R7 R9: table walk
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][30:15], VEC[v][14], VEC[v][13]);
            chk("R2/R4", "fire", 16'(pt_fire), 16'(VEC[v][12:9]));
            chk("R9", "trig", 16'(trig_out), 16'(VEC[v][8]));
            chk("R6", "match", 16'(match_flags), 16'(VEC[v][7:4]));
            chk("R7", "err", 16'(err_flags), 16'(VEC[v][3:0]));
        end

        // R8 interrupt masking
        chk("R8", "irq masked", 16'(err_irq), 16'h0);
        err_irq_en = 1'b1;
        #1;
        chk("R8", "irq enabled", 16'(err_irq), 16'h1);
        err_irq_en = 1'b0;

        // R6 R7 clearing
        clr_match = 4'b1111;
        clr_err   = 4'b1000;
        step(16'd22, 1'b0, 1'b0);
        clr_match = '0;
        clr_err   = '0;
        chk("R6", "match cleared", 16'(match_flags), 16'h0);
        chk("R7", "err cleared", 16'(err_flags), 16'h0);

        // R10 shadow write without load has no effect
        wr_dly(2'd0, 16'd7);
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R10", "unloaded value ignored", 16'(pt_fire), 16'h0);
        step(16'd5, 1'b0, 1'b0);
        chk("R10", "old value used", 16'(pt_fire), 16'h1);
        step(16'd6, 1'b0, 1'b1);
        do_load();
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R10", "loaded value used", 16'(pt_fire), 16'h1);
        step(16'd8, 1'b0, 1'b1);

        // R5 R7 priority with equal delays, overlap error on the second
        wr_dly(2'd1, 16'd7);
        do_load();
        pt_enable = 4'b0011;
        pt_outsel = 4'b0011;
        pt_chain  = 4'b0000;
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R5", "lowest first", 16'(pt_fire), 16'h1);
        step(16'd8, 1'b0, 1'b0);
        chk("R5", "next in order", 16'(pt_fire), 16'h2);
        chk("R7", "overlap flagged", 16'(err_flags), 16'h2);
        step(16'd9, 1'b0, 1'b1);

        // R3 output-select or enable clear blocks a slot
        pt_outsel = 4'b0010;
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R3", "outsel off", 16'(pt_fire), 16'h2);
        step(16'd9, 1'b0, 1'b1);
        pt_outsel = 4'b0011;
        pt_enable = 4'b0010;
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R3", "enable off", 16'(pt_fire), 16'h2);
        step(16'd9, 1'b0, 1'b1);

        // R4 chain bit on slot 0 ignored
        pt_enable = 4'b0001;
        pt_outsel = 4'b0001;
        pt_chain  = 4'b0001;
        step(16'd0, 1'b1, 1'b0);
        step(16'd7, 1'b0, 1'b0);
        chk("R4", "slot0 chain ignored", 16'(pt_fire), 16'h1);
        step(16'd9, 1'b0, 1'b1);
        // R9 last armed is slot 0 here
        chk("R9", "trig falls", 16'(trig_out), 16'h0);

        finish_run();
    end

endmodule